// File: doc/BRIEF.md
# Stereo Audio Serial Receiver

This block takes two-channel 24-bit PCM audio from a three-wire serial link and turns it into parallel left/right sample pairs. The link carries a bit clock, a word clock whose level says which channel is on the wire, and one data line. The block runs directly on the bit clock. It samples the word clock and the data on every rising edge. A single format input selects between MSB-justified framing and I2S framing.

Each word-clock transition restarts the bit counter. The first 24 bits of each half-frame are shifted in MSB first. Any further bits in that half-frame are dropped. If a half-frame ends before 24 bits have arrived, the bits that did not arrive read as zero. When a right word completes after a left word, both words appear together on the outputs with a one-cycle valid strobe. A downstream interpolation or mixing stage consumes the pair.

Top module: `stereo_serial_rx`

## Requirements
- R1: With `fmt_i2s` low, a word's MSB is the data bit sampled on the first rising bit-clock edge at which the word clock shows its new level, and the left channel is the half-frame with the word clock high.
- R2: With `fmt_i2s` high, a word's MSB is sampled one bit clock later than in R1, and the left channel is the half-frame with the word clock low.
- R3: Each word is 24-bit two's complement, MSB first. Data bits after the 24th in a half-frame do not change the received word.
- R4: Frames of 48 bit clocks (24 per half-frame) are received correctly in both formats. This includes I2S, where a word's LSB falls on the first bit clock after the next word-clock edge.
- R5: A word cut short by a word-clock edge before its 24th bit is delivered with every missing low-order bit equal to zero.
- R6: `valid_o` is high for exactly one cycle per left/right pair. It is visible after the rising edge 24 bit clocks after the first rising edge of the right half-frame. `left_o` and `right_o` change only together with `valid_o`.
- R7: During reset `valid_o`, `left_o` and `right_o` are zero. After reset a right word that has no left word before it produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Word clock; its level selects the channel, its edges start words |
| sdata | input | 1 | Serial audio data |
| fmt_i2s | input | 1 | 0 selects MSB-justified framing, 1 selects I2S framing |
| left_o | output | 24 | Left sample of the last completed pair |
| right_o | output | 24 | Right sample of the last completed pair |
| valid_o | output | 1 | One-cycle strobe marking a new pair |

## Verification
The spacing assertion assumes that every frame spans at least 48 bit clocks. This means two pulses are never closer than 48 cycles. The stimulus therefore uses only frames of 48 or 64 clocks, including the uneven 20/44 split. The assertions also assume that the word clock and the data change only between rising edges and that the format input is held steady within a run. The bench changes both only on falling edges, and it changes the format only while reset is held.

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx #(
  parameter int W = 24
) (
  input  logic         bclk,
  input  logic         rst_n,
  input  logic         lrclk,
  input  logic         sdata,
  input  logic         fmt_i2s,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);
  localparam int IW = $clog2(W + 1);
  localparam logic [IW-1:0] LAST = IW'(W - 1);

  logic [1:0]    prime;
  logic          lr_q, lr_qq, sd_q;
  logic [W-1:0]  sh, nw, lhold, cword;
  logic [IW-1:0] idx;
  logic          busy, cur_left, lgot;

  wire edge_d = prime[1] & (lr_q ^ lr_qq);
  wire din    = fmt_i2s ? sdata : sd_q;
  wire cut    = edge_d & busy;
  wire full   = ~edge_d & busy & (idx == LAST);
  wire commit = cut | full;

  always_comb begin
    nw = sh;
    if (busy) nw[LAST - idx] = din;
  end

  assign cword = cut ? sh : nw;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      prime    <= '0;
      lr_q     <= 1'b0;
      lr_qq    <= 1'b0;
      sd_q     <= 1'b0;
      sh       <= '0;
      idx      <= '0;
      busy     <= 1'b0;
      cur_left <= 1'b0;
      lgot     <= 1'b0;
      lhold    <= '0;
      left_o   <= '0;
      right_o  <= '0;
      valid_o  <= 1'b0;
    end else begin
      prime   <= {prime[0], 1'b1};
      lr_q    <= lrclk;
      lr_qq   <= lr_q;
      sd_q    <= sdata;
      valid_o <= 1'b0;
      if (edge_d) begin
        sh       <= {din, {(W-1){1'b0}}};
        idx      <= IW'(1);
        busy     <= 1'b1;
        cur_left <= fmt_i2s ? ~lr_q : lr_q;
      end else if (busy) begin
        sh  <= nw;
        idx <= idx + 1'b1;
        if (idx == LAST) busy <= 1'b0;
      end
      if (commit) begin
        if (cur_left) begin
          lhold <= cword;
          lgot  <= 1'b1;
        end else begin
          lgot <= 1'b0;
          if (lgot) begin
            left_o  <= lhold;
            right_o <= cword;
            valid_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/stereo_serial_rx_chk.sv
module stereo_serial_rx_chk #(
  parameter int W = 24
) (
  input logic         bclk,
  input logic         rst_n,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         valid_o
);
  logic [5:0] gap;
  logic       seen;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (valid_o) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 6'd63) begin
      gap <= gap + 6'd1;
    end
  end

  a_r6_single_pulse: assert property (@(posedge bclk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  a_r6_outputs_move_with_valid: assert property (@(posedge bclk) disable iff (!rst_n)
    ((left_o != $past(left_o)) || (right_o != $past(right_o))) |-> valid_o);

  a_r7_quiet_in_reset: assert property (@(posedge bclk)
    !rst_n |-> (!valid_o && left_o == '0 && right_o == '0));

  a_r4_pulse_spacing: assert property (@(posedge bclk) disable iff (!rst_n)
    (valid_o && seen) |-> (gap >= 6'd47));
endmodule

bind stereo_serial_rx stereo_serial_rx_chk #(.W(W)) u_chk (
  .bclk(bclk), .rst_n(rst_n), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
);

// File: tb/tb_stereo_serial_rx.sv
module tb_stereo_serial_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lrclk = 1'b0;
  logic sdata = 1'b0;
  logic fmt_i2s = 1'b0;
  logic [23:0] left_o, right_o;
  logic valid_o;

  stereo_serial_rx dut (
    .bclk(clk), .rst_n(rst_n), .lrclk(lrclk), .sdata(sdata), .fmt_i2s(fmt_i2s),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always #2.5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int drv_n = 0;
  int pcnt = 0;
  logic [23:0] pl [8];
  logic [23:0] pr [8];
  int pt [8];
  logic [23:0] lw [4];
  logic [23:0] rw [4];
  int rs [4];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && valid_o && pcnt < 8) begin
      pl[pcnt] = left_o;
      pr[pcnt] = right_o;
      pt[pcnt] = drv_n;
      pcnt++;
    end
  end

  task automatic drive(input logic lev, input logic b);
    @(negedge clk);
    lrclk = lev;
    sdata = b;
    drv_n++;
  endtask

  function automatic logic bitv(input bit fmt, input int c, input logic [23:0] w,
                                input logic [23:0] pw, input int pn);
    int k;
    if (fmt) begin
      if (c == 0) return (pn <= 24) ? pw[24 - pn] : 1'b1;
      k = c - 1;
    end else begin
      k = c;
    end
    return (k < 24) ? w[23 - k] : 1'b1;
  endfunction

  task automatic do_reset(input bit fmt, input logic idle_lev);
    @(negedge clk);
    rst_n = 1'b0;
    fmt_i2s = fmt;
    lrclk = idle_lev;
    sdata = 1'b1;
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R7", "valid in reset", 24'(valid_o), 24'h0);
    chk(left_o == 24'h0, "R7", "left in reset", left_o, 24'h0);
    chk(right_o == 24'h0, "R7", "right in reset", right_o, 24'h0);
    rst_n = 1'b1;
  endtask

  task automatic run_case(input string req, input bit fmt, input int nl, input int nr,
                          input int nf, input int seed, input bit lead_right);
    logic ll;
    logic [23:0] pw;
    int pn;
    logic [23:0] mask;
    ll = fmt ? 1'b0 : 1'b1;
    for (int f = 0; f < nf; f++) begin
      lw[f] = 24'(seed * 24'h1F35 + f * 24'h3A7C1) ^ 24'h800000;
      rw[f] = 24'(seed * 24'h0B29 + f * 24'h51E3) ^ 24'h7FFF00;
    end
    if (nf > 1) rw[1] = 24'h800000;
    do_reset(fmt, lead_right ? ll : ~ll);
    pcnt = 0;
    pw = 24'h0;
    pn = 64;
    for (int c = 0; c < 40; c++) drive(lead_right ? ll : ~ll, 1'b1);
    if (lead_right) begin
      for (int c = 0; c < 32; c++) drive(~ll, bitv(fmt, c, 24'h5A5A5A, pw, pn));
      pw = 24'h5A5A5A;
      pn = 32;
    end
    for (int f = 0; f < nf; f++) begin
      for (int c = 0; c < nl; c++) drive(ll, bitv(fmt, c, lw[f], pw, pn));
      pw = lw[f];
      pn = nl;
      rs[f] = drv_n + 1;
      for (int c = 0; c < nr; c++) drive(~ll, bitv(fmt, c, rw[f], pw, pn));
      pw = rw[f];
      pn = nr;
    end
    for (int c = 0; c < 30; c++) drive(ll, bitv(fmt, c, 24'hFFFFFF, pw, pn));
    repeat (3) @(negedge clk);
    chk(pcnt == nf, "R6", $sformatf("%s pulse count", req), 24'(pcnt), 24'(nf));
    mask = (nl >= 24) ? 24'hFFFFFF : ~((24'h1 << (24 - nl)) - 24'h1);
    for (int f = 0; f < nf && f < pcnt; f++) begin
      chk(pl[f] == (lw[f] & mask), req, $sformatf("left word %0d", f), pl[f], lw[f] & mask);
      chk(pr[f] == rw[f], req, $sformatf("right word %0d", f), pr[f], rw[f]);
      chk(pt[f] == rs[f] + 24, "R6", $sformatf("%s pulse slot %0d", req, f),
          24'(pt[f]), 24'(rs[f] + 24));
    end
  endtask

  task automatic t_msb_64();   run_case("R1 R3", 1'b0, 32, 32, 3, 5, 1'b0); endtask
  task automatic t_i2s_64();   run_case("R2 R3", 1'b1, 32, 32, 3, 9, 1'b0); endtask
  task automatic t_i2s_48();   run_case("R4 i2s", 1'b1, 24, 24, 3, 13, 1'b0); endtask
  task automatic t_msb_48();   run_case("R4 msb", 1'b0, 24, 24, 2, 17, 1'b0); endtask
  task automatic t_msb_cut();  run_case("R5 msb", 1'b0, 20, 44, 2, 21, 1'b0); endtask
  task automatic t_i2s_cut();  run_case("R5 i2s", 1'b1, 20, 44, 2, 25, 1'b0); endtask
  task automatic t_lone_right(); run_case("R7 lone right", 1'b0, 32, 32, 2, 29, 1'b1); endtask

  initial begin
    #(5.0 * 150000);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_msb_64();
    t_i2s_64();
    t_i2s_48();
    t_msb_48();
    t_msb_cut();
    t_i2s_cut();
    t_lone_right();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule